// File: doc/BRIEF.md
# Per-Channel Trigger Condition Matcher

This block decides, on every rising edge of the acquisition clock, whether a set of sampled channels meets a trigger condition. Each of the `NCH` channels has its own three-bit condition code, and so does one external trigger input. A code asks for a level (high or low) or an edge (rising, falling or either), or it masks the source out of the match. The trigger fires only when every source that is not masked meets its condition in the same cycle.

The block then raises a one-cycle trigger strobe and drives a trigger-output pulse whose active level is selectable. Condition codes and the polarity sit in small registers that a plain write port can rewrite while the design runs.

A three-state machine controls arming:
- `S_IDLE` is the disarmed state. It also marks the first armed cycle, because no previous sample is valid yet.
- `S_WATCH` means the block is armed and edges can be evaluated.
- `S_DONE` means the block has fired and waits for disarm.

The transitions are:
- IDLE→WATCH when armed with no hit.
- IDLE→DONE or WATCH→DONE on a hit.
- WATCH→WATCH while armed with no hit.
- DONE→DONE while armed.
- Any state→IDLE when `arm` drops.

Top module: `trig_match`

## Requirements
- R1: Condition codes are 3 bits: 0 masked (don't care), 1 low, 2 high, 3 rising, 4 falling, 5 either edge. Write address k (0..NCH-1) selects channel k, address NCH selects the external input, and address NCH+1 bit 0 selects the polarity.
- R2: After reset, every condition is masked, the polarity is active high, and both `trig_hit` and `trig_out` are 0.
- R3: A low condition is met when the source is 0 in the evaluated cycle, and a high condition when it is 1.
- R4: Edge conditions compare the current sample with the sample taken at the previous edge. No edge condition is met on the first armed cycle.
- R5: The trigger fires only when all unmasked sources, channels and external input together, meet their conditions in the same cycle. A partial match never fires.
- R6: The external trigger input is matched through its own condition register, with the same six choices.
- R7: `trig_hit` rises only for a cycle in which `arm` was high. It rises at most once per arming, until `arm` has been low for a cycle.
- R8: `trig_hit` and the active `trig_out` pulse last exactly one clock cycle and follow the matching edge.
- R9: With polarity bit 0, `trig_out` idles at 0 and pulses to 1. With polarity bit 1, it idles at 1 and pulses to 0.
- R10: A configuration write takes effect from the next edge. If every condition is masked, the block fires on the first armed cycle.
- R11: Codes 6 and 7 behave as masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Acquisition clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm | input | 1 | Level enable for trigger recognition |
| ch_in | input | NCH | Sampled channels |
| ext_in | input | 1 | External trigger input |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(NCH+2) | Configuration register select |
| cfg_data | input | 3 | Write data (condition code or polarity in bit 0) |
| trig_hit | output | 1 | One-cycle internal trigger strobe |
| trig_out | output | 1 | Trigger-output pulse, polarity selectable |

## Verification
A wrong state register shows up at the ports on the very next edge:
- A block stuck in `S_DONE` never strobes again after re-arming.
- A block that leaves `S_DONE` early strobes twice in one arming.
- A block that enters `S_WATCH` too soon lets an edge condition fire on the first armed cycle.

A corrupted previous-sample register or condition register gives a strobe that is missing or extra in the cycle after the stimulus. A wrong polarity bit flips the idle level of `trig_out` one cycle after the write.

// File: rtl/trig_pkg.sv
package trig_pkg;

    localparam int COND_W = 3;

    localparam logic [COND_W-1:0] C_ANY    = 3'd0;
    localparam logic [COND_W-1:0] C_LOW    = 3'd1;
    localparam logic [COND_W-1:0] C_HIGH   = 3'd2;
    localparam logic [COND_W-1:0] C_RISE   = 3'd3;
    localparam logic [COND_W-1:0] C_FALL   = 3'd4;
    localparam logic [COND_W-1:0] C_EITHER = 3'd5;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_WATCH = 2'd1,
        S_DONE  = 2'd2
    } arm_state_e;

endpackage

// File: rtl/trig_cond_cell.sv
module trig_cond_cell
    import trig_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  logic              cur,
    input  logic              prev,
    input  logic              prev_ok,
    output logic              met
);
    always_comb begin
        unique case (cond)
            C_LOW:    met = ~cur;
            C_HIGH:   met = cur;
            C_RISE:   met = prev_ok & cur & ~prev;
            C_FALL:   met = prev_ok & ~cur & prev;
            C_EITHER: met = prev_ok & (cur ^ prev);
            default:  met = 1'b1;   // masked, including spare codes
        endcase
    end
endmodule

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
    import trig_pkg::*;
#(
    parameter int NSRC = 9,
    parameter int AW   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [AW-1:0]               addr,
    input  logic [COND_W-1:0]           data,
    output logic [NSRC-1:0][COND_W-1:0] cond,
    output logic                        pol_low
);
    for (genvar g = 0; g < NSRC; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cond[g] <= C_ANY;
            else if (we && addr == AW'(g))
                cond[g] <= data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pol_low <= 1'b0;
        else if (we && addr == AW'(NSRC))
            pol_low <= data[0];
    end
endmodule

// File: rtl/trig_match.sv
module trig_match
    import trig_pkg::*;
#(
    parameter int NCH = 8,
    localparam int NSRC = NCH + 1,
    localparam int AW = $clog2(NCH + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [NCH-1:0]    ch_in,
    input  logic              ext_in,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [COND_W-1:0] cfg_data,
    output logic              trig_hit,
    output logic              trig_out
);
    logic [NSRC-1:0][COND_W-1:0] cond;
    logic                        pol_low;
    logic [NSRC-1:0]             src, src_prev, met;
    arm_state_e                  state_q, state_d;
    logic                        hit_c;

    assign src = {ext_in, ch_in};

    trig_cfg_regs #(.NSRC(NSRC), .AW(AW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .data(cfg_data), .cond(cond), .pol_low(pol_low)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_prev <= '0;
        else        src_prev <= src;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_cell
        trig_cond_cell u_cell (
            .cond(cond[g]), .cur(src[g]), .prev(src_prev[g]),
            .prev_ok(state_q == S_WATCH), .met(met[g])
        );
    end

    assign hit_c = arm && (state_q != S_DONE) && (&met);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  state_d = !arm ? S_IDLE : (hit_c ? S_DONE : S_WATCH);
            S_WATCH: state_d = !arm ? S_IDLE : (hit_c ? S_DONE : S_WATCH);
            S_DONE:  state_d = !arm ? S_IDLE : S_DONE;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_hit <= 1'b0;
            trig_out <= 1'b0;
        end else begin
            trig_hit <= hit_c;
            trig_out <= hit_c ^ pol_low;
        end
    end
endmodule

// File: rtl/trig_match_chk.sv
module trig_match_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       arm,
    input logic       ch0,
    input logic [2:0] cond0,
    input logic       done,
    input logic       trig_hit
);
    // R7
    hit_only_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_hit |-> $past(arm));

    // R8
    hit_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_hit |=> !trig_hit);

    // R7
    no_refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && arm) |=> !trig_hit);

    // R4
    rise_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_hit && $past(cond0) == 3'd3) |-> ($past(ch0) && !$past(ch0, 2)));

    // R4
    fall_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_hit && $past(cond0) == 3'd4) |-> (!$past(ch0) && $past(ch0, 2)));
endmodule

bind trig_match trig_match_chk u_chk (
    .clk(clk), .rst_n(rst_n), .arm(arm), .ch0(ch_in[0]), .cond0(cond[0]),
    .done(state_q == trig_pkg::S_DONE), .trig_hit(trig_hit)
);

// File: tb/trig_match_tb.sv
module trig_match_tb;
    localparam int NCH = 8;
    localparam int AW  = $clog2(NCH + 2);

    typedef struct {
        logic  hit;
        logic  out;
        string tag;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           arm = 1'b0;
    logic [NCH-1:0] ch_in = '0;
    logic           ext_in = 1'b0;
    logic           cfg_we = 1'b0;
    logic [AW-1:0]  cfg_addr = '0;
    logic [2:0]     cfg_data = '0;
    logic           trig_hit, trig_out;

    exp_t q[$];
    int   n_chk = 0, n_fail = 0;
    logic pol_m = 1'b0;
    bit   finished = 0;

    always #2.5 clk = ~clk;

    trig_match #(.NCH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .ch_in(ch_in), .ext_in(ext_in),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .trig_hit(trig_hit), .trig_out(trig_out)
    );

    // monitor: one expectation per clock edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (trig_hit !== e.hit || trig_out !== e.out) begin
                    n_fail++;
                    $display("FAIL %s: hit/out=%b%b expected %b%b",
                             e.tag, trig_hit, trig_out, e.hit, e.out);
                end
            end
        end
    end

    task automatic step(input logic [NCH-1:0] c, input logic x, input logic a,
                        input logic eh, input string tag);
        @(negedge clk);
        cfg_we = 1'b0;
        ch_in  = c;
        ext_in = x;
        arm    = a;
        q.push_back('{eh, eh ^ pol_m, tag});
    endtask

    task automatic wr(input int addr, input logic [2:0] d, input string tag);
        @(negedge clk);
        arm      = 1'b0;
        cfg_we   = 1'b1;
        cfg_addr = AW'(addr);
        cfg_data = d;
        q.push_back('{1'b0, pol_m, tag});
        if (addr == NCH + 1) pol_m = d[0];
    endtask

    initial begin
        #8000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: finished=0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #12;
        // R2 reset state
        n_chk++;
        if (trig_hit !== 1'b0 || trig_out !== 1'b0) begin
            n_fail++;
            $display("FAIL R2: hit/out=%b%b expected 00", trig_hit, trig_out);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R10 / R2: all masked after reset, fires on first armed cycle
        step(8'h00, 0, 0, 0, "R2 disarmed idle");
        step(8'h5A, 0, 1, 1, "R10 all masked first armed cycle");
        step(8'h5A, 0, 1, 0, "R7 no refire while armed");
        step(8'h00, 0, 1, 0, "R8 single cycle");
        step(8'h00, 0, 0, 0, "R7 disarm");

        // R3 levels: ch0 high, ch1 low (R1 codes 2 and 1)
        wr(0, 3'd2, "R1 write ch0 high");
        wr(1, 3'd1, "R1 write ch1 low");
        step(8'h00, 0, 1, 0, "R3 ch0 low fails");
        step(8'h02, 0, 1, 0, "R5 both fail");
        step(8'h03, 0, 1, 0, "R5 partial match");
        step(8'h01, 0, 1, 1, "R3 levels met");
        step(8'h01, 0, 0, 0, "R7 disarm");

        // R4 rising on ch2
        wr(0, 3'd0, "R1 mask ch0");
        wr(1, 3'd0, "R1 mask ch1");
        wr(2, 3'd3, "R1 write ch2 rise");
        step(8'h00, 0, 0, 0, "R4 setup");
        step(8'h04, 0, 1, 0, "R4 no edge on first armed cycle");
        step(8'h04, 0, 1, 0, "R4 steady high");
        step(8'h00, 0, 1, 0, "R4 falling not rising");
        step(8'h04, 0, 1, 1, "R4 rising edge");
        step(8'h04, 0, 0, 0, "R7 disarm");

        // R4 falling on ch2
        wr(2, 3'd4, "R1 write ch2 fall");
        step(8'h04, 0, 1, 0, "R4 fall first armed");
        step(8'h00, 0, 1, 1, "R4 falling edge");
        step(8'h00, 0, 0, 0, "R7 disarm");

        // R4 either edge on ch2
        wr(2, 3'd5, "R1 write ch2 either");
        step(8'h00, 0, 1, 0, "R4 either first armed");
        step(8'h00, 0, 1, 0, "R4 either steady");
        step(8'h04, 0, 1, 1, "R4 either rising");
        step(8'h04, 0, 0, 0, "R7 disarm");
        step(8'h04, 0, 1, 0, "R7 rearm first cycle");
        step(8'h00, 0, 1, 1, "R4 either falling after rearm");
        step(8'h00, 0, 0, 0, "R7 disarm");

        // R11 spare codes masked
        wr(2, 3'd6, "R11 write code 6");
        wr(3, 3'd7, "R11 write code 7");
        step(8'h00, 0, 1, 1, "R11 codes 6 and 7 masked");
        step(8'h00, 0, 0, 0, "R7 disarm");

        // R6 external input
        wr(2, 3'd0, "R1 mask ch2");
        wr(3, 3'd0, "R1 mask ch3");
        wr(NCH, 3'd2, "R6 write ext high");
        step(8'hFF, 0, 1, 0, "R6 ext low fails");
        step(8'hFF, 1, 1, 1, "R6 ext high met");
        step(8'hFF, 1, 0, 0, "R7 disarm");
        wr(NCH, 3'd3, "R6 write ext rise");
        step(8'hFF, 1, 1, 0, "R6 ext rise first armed");
        step(8'hFF, 0, 1, 0, "R6 ext falls");
        step(8'hFF, 1, 1, 1, "R6 ext rising edge");
        step(8'hFF, 1, 0, 0, "R7 disarm");

        // R5 ext edge and channel level together
        wr(5, 3'd2, "R1 write ch5 high");
        step(8'h00, 0, 1, 0, "R5 first armed");
        step(8'h00, 1, 1, 0, "R5 ext rises but ch5 low");
        step(8'h20, 0, 1, 0, "R5 ch5 high but ext falls");
        step(8'h20, 1, 1, 1, "R5 all met together");
        step(8'h20, 1, 0, 0, "R7 disarm");

        // R9 polarity active low
        wr(NCH + 1, 3'd1, "R9 write polarity low");
        wr(NCH, 3'd0, "R1 mask ext");
        wr(5, 3'd0, "R1 mask ch5");
        step(8'h00, 0, 0, 0, "R9 idle level high");
        step(8'h00, 0, 1, 1, "R9 active low pulse");
        step(8'h00, 0, 1, 0, "R8 pulse one cycle");
        step(8'h00, 0, 0, 0, "R7 disarm");
        wr(NCH + 1, 3'd0, "R9 write polarity high");
        step(8'h00, 0, 0, 0, "R9 idle level low again");

        // R7 disarmed never fires
        step(8'hFF, 1, 0, 0, "R7 disarmed all masked");
        step(8'h00, 0, 0, 0, "R7 disarmed all masked");

        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule